// File: doc/BRIEF.md
# Deep-Pipeline Hazard and Stall Controller

This block controls hazards for an eight-stage in-order integer pipeline. The stages are fetch start, fetch finish, decode/register read, execute, data access start, data access finish, tag check and write-back. Data-cache reads take two stages, so a load's result is ready only at the end of the data-access-finish stage, two stages after execute. A branch is predicted not taken and resolves in execute. A tag-check miss is found after younger instructions have already moved forward.

The front end presents the instruction now in decode each cycle: its valid bit, two source register numbers, a destination number, and load and branch flags. The controller keeps its own record of what occupies execute, both data-access stages and tag check. From that record it drives four things:
- a front-end hold when a load result is not yet ready or a refill is pending;
- a squash of the two fetch stages when a branch is taken;
- a full flush when a load misses;
- registered operand-bypass selects for the instruction that enters execute.

After a flush it reports busy and holds fetch until refill completion is signalled. It then pulses a replay strobe so that the front end restarts from the missed load.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: Reset behaviour. After a synchronous reset, `busy`, `replay`, `byp_a` and `byp_b` are 0. No operand finds a producer in flight, so `stall_front`, `kill_front` and `flush_all` stay 0 for any decode input.
- R2: Adjacent load use. An instruction in decode that reads the destination of the load directly ahead of it holds `stall_front` high for exactly two cycles: one while the load is in execute and one while it is in data-access-start.
- R3: One instruction between. A reader with one instruction between it and the load is held for exactly one cycle.
- R4: Load bypass. A reader that enters execute while the load moves into tag check gets bypass code 3. A reader that enters execute while the load moves into write-back gets code 4.
- R5: Bypass code meaning. Code k (1 to 4) selects the result of the producer that will sit in data-access-start, data-access-finish, tag check or write-back (k = 1, 2, 3, 4) while the consumer executes. Code 0 selects the register file. When several producers match, the youngest wins. Codes are registered and appear in the cycle the consumer is in execute.
- R6: Register 0. Register 0 is never a producer or a dependency. A load to register 0 causes no hold, and a destination of 0 never yields a nonzero code.
- R7: Taken branch. When execute holds a branch and `ex_taken` is 1, `kill_front` is 1 in that same cycle. The delay-slot instruction in decode is not held and enters execute on the next cycle.
- R8: Not taken. `ex_taken` has no effect unless execute holds a branch, and an untaken branch never raises `kill_front`.
- R9: Miss on a load. `tc_miss` while tag check holds a load raises `flush_all` in that cycle. `busy` is 1 from the next cycle, `stall_front` stays 1 while `busy` is 1, and nothing from decode enters execute.
- R10: Miss ignored. `tc_miss` has no effect when tag check holds a non-load or an empty slot, or while `busy` is already 1.
- R11: Refill. `refill_done` while `busy` is 1 clears `busy` on the next cycle, and in that same cycle `replay` is high for one cycle.
- R12: Miss wins. A flush takes priority over a taken branch resolving in the same cycle, so `kill_front` stays 0.
- R13: Bubble after hold. In the cycle after `stall_front` or `flush_all` was 1, both bypass codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_valid | input | 1 | Decode stage holds an instruction |
| rf_src_a | input | REG_W | First source register of the decode instruction |
| rf_src_b | input | REG_W | Second source register of the decode instruction |
| rf_dst | input | REG_W | Destination register (0 means no write) |
| rf_is_load | input | 1 | Decode instruction is a load |
| rf_is_branch | input | 1 | Decode instruction is a branch |
| ex_taken | input | 1 | The branch in execute resolved taken |
| tc_miss | input | 1 | Tag check reports a data-cache miss |
| refill_done | input | 1 | The missed line has been filled |
| stall_front | output | 1 | Hold fetch and decode, send a bubble into execute |
| kill_front | output | 1 | Turn the two fetch-stage instructions into no-ops |
| flush_all | output | 1 | Discard every instruction from fetch through tag check |
| busy | output | 1 | Waiting for a refill after a miss |
| replay | output | 1 | One-cycle pulse: refetch from the missed load |
| byp_a | output | CODE_W | Bypass select for operand A of the execute instruction |
| byp_b | output | CODE_W | Bypass select for operand B of the execute instruction |

## Verification
A corrupted in-flight record shows at the ports one or two cycles later. A lost load flag drops one of the two hold cycles on the next decode cycle. A wrong destination field gives a wrong bypass code on the cycle the consumer executes. A stuck wait state keeps `stall_front` high and `replay` silent from the cycle after `refill_done`. Shifting a load by a single stage changes the stall count and moves the code from 3 to 4. The vectors therefore place producers at each distance and check every cycle.

// File: rtl/phc_pkg.sv
package phc_pkg;
  typedef enum logic {
    MS_RUN  = 1'b0,
    MS_WAIT = 1'b1
  } miss_state_e;

  localparam int unsigned CODE_REGFILE = 0;
endpackage

// File: rtl/phc_shadow.sv
// Record of the instructions in execute, both data-access stages and tag check.
module phc_shadow #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         adv,
  input  logic                         flush,
  input  logic [REG_W-1:0]             in_dst,
  input  logic                         in_ld,
  input  logic                         in_br,
  output logic [DEPTH-1:0]             st_vld,
  output logic [DEPTH-1:0][REG_W-1:0]  st_dst,
  output logic [DEPTH-1:0]             st_ld,
  output logic                         ex_br
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      st_vld[0] <= 1'b0;
      ex_br     <= 1'b0;
    end else begin
      st_vld[0] <= adv;
      ex_br     <= adv & in_br;
    end
    st_dst[0] <= in_dst;
    st_ld[0]  <= in_ld;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst || flush) st_vld[g] <= 1'b0;
      else              st_vld[g] <= st_vld[g-1];
      st_dst[g] <= st_dst[g-1];
      st_ld[g]  <= st_ld[g-1];
    end
  end
endmodule

// File: rtl/phc_hazard.sv
// Load-use hold detection and youngest-first bypass selection for decode.
module phc_hazard #(
  parameter int unsigned REG_W     = 5,
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned LU_STAGES = 2,
  parameter int unsigned CODE_W    = 3
) (
  input  logic                         rf_valid,
  input  logic [REG_W-1:0]             src_a,
  input  logic [REG_W-1:0]             src_b,
  input  logic [DEPTH-1:0]             st_vld,
  input  logic [DEPTH-1:0][REG_W-1:0]  st_dst,
  input  logic [DEPTH-1:0]             st_ld,
  output logic                         lu_hazard,
  output logic [CODE_W-1:0]            code_a,
  output logic [CODE_W-1:0]            code_b
);
  logic [DEPTH-1:0] writes;
  logic [DEPTH-1:0] fwd_ok;
  logic [DEPTH-1:0] not_ready;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cls
    assign writes[g]    = st_vld[g] && (st_dst[g] != '0);
    assign fwd_ok[g]    = writes[g] && (!st_ld[g] || (g >= LU_STAGES));
    assign not_ready[g] = writes[g] && st_ld[g] && (g < LU_STAGES);
  end

  always_comb begin
    lu_hazard = 1'b0;
    code_a    = CODE_W'(phc_pkg::CODE_REGFILE);
    code_b    = CODE_W'(phc_pkg::CODE_REGFILE);
    // oldest first so that younger matches overwrite
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (fwd_ok[i] && st_dst[i] == src_a) code_a = CODE_W'(i + 1);
      if (fwd_ok[i] && st_dst[i] == src_b) code_b = CODE_W'(i + 1);
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (rf_valid && not_ready[i] &&
          (st_dst[i] == src_a || st_dst[i] == src_b))
        lu_hazard = 1'b1;
    end
  end
endmodule

// File: rtl/phc_miss_ctl.sv
// Miss backup sequencing: flush, wait for refill, replay strobe.
module phc_miss_ctl (
  input  logic clk,
  input  logic rst,
  input  logic tc_vld,
  input  logic tc_ld,
  input  logic tc_miss,
  input  logic refill_done,
  output logic flush,
  output logic busy,
  output logic replay
);
  import phc_pkg::*;

  miss_state_e state_q;

  assign flush = (state_q == MS_RUN) && tc_vld && tc_ld && tc_miss;
  assign busy  = (state_q == MS_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MS_RUN;
      replay  <= 1'b0;
    end else begin
      replay <= (state_q == MS_WAIT) && refill_done;
      case (state_q)
        MS_RUN:  if (flush)       state_q <= MS_WAIT;
        MS_WAIT: if (refill_done) state_q <= MS_RUN;
        default:                  state_q <= MS_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
  parameter  int unsigned REG_W     = 5,
  parameter  int unsigned DEPTH     = 4,
  parameter  int unsigned LU_STAGES = 2,
  localparam int unsigned CODE_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rf_valid,
  input  logic [REG_W-1:0]  rf_src_a,
  input  logic [REG_W-1:0]  rf_src_b,
  input  logic [REG_W-1:0]  rf_dst,
  input  logic              rf_is_load,
  input  logic              rf_is_branch,
  input  logic              ex_taken,
  input  logic              tc_miss,
  input  logic              refill_done,
  output logic              stall_front,
  output logic              kill_front,
  output logic              flush_all,
  output logic              busy,
  output logic              replay,
  output logic [CODE_W-1:0] byp_a,
  output logic [CODE_W-1:0] byp_b
);
  localparam int unsigned TC_IDX = DEPTH - 1;

  logic [DEPTH-1:0]            st_vld;
  logic [DEPTH-1:0][REG_W-1:0] st_dst;
  logic [DEPTH-1:0]            st_ld;
  logic                        ex_br;
  logic                        lu_hazard;
  logic [CODE_W-1:0]           code_a;
  logic [CODE_W-1:0]           code_b;
  logic                        adv;

  assign stall_front = lu_hazard | busy;
  assign adv         = rf_valid & ~stall_front & ~flush_all;
  assign kill_front  = st_vld[0] & ex_br & ex_taken & ~flush_all;

  phc_shadow #(.REG_W(REG_W), .DEPTH(DEPTH)) shadow_i (
    .clk    (clk),
    .rst    (rst),
    .adv    (adv),
    .flush  (flush_all),
    .in_dst (rf_dst),
    .in_ld  (rf_is_load),
    .in_br  (rf_is_branch),
    .st_vld (st_vld),
    .st_dst (st_dst),
    .st_ld  (st_ld),
    .ex_br  (ex_br)
  );

  phc_hazard #(
    .REG_W(REG_W), .DEPTH(DEPTH), .LU_STAGES(LU_STAGES), .CODE_W(CODE_W)
  ) hazard_i (
    .rf_valid  (rf_valid),
    .src_a     (rf_src_a),
    .src_b     (rf_src_b),
    .st_vld    (st_vld),
    .st_dst    (st_dst),
    .st_ld     (st_ld),
    .lu_hazard (lu_hazard),
    .code_a    (code_a),
    .code_b    (code_b)
  );

  phc_miss_ctl miss_i (
    .clk         (clk),
    .rst         (rst),
    .tc_vld      (st_vld[TC_IDX]),
    .tc_ld       (st_ld[TC_IDX]),
    .tc_miss     (tc_miss),
    .refill_done (refill_done),
    .flush       (flush_all),
    .busy        (busy),
    .replay      (replay)
  );

  always_ff @(posedge clk) begin
    if (rst || !adv) begin
      byp_a <= '0;
      byp_b <= '0;
    end else begin
      byp_a <= code_a;
      byp_b <= code_b;
    end
  end
endmodule

// File: rtl/pipe_hazard_ctl_chk.sv
module pipe_hazard_ctl_chk #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned MAX_CODE = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              stall_front,
  input logic              kill_front,
  input logic              flush_all,
  input logic              busy,
  input logic              replay,
  input logic [CODE_W-1:0] byp_a,
  input logic [CODE_W-1:0] byp_b
);
  AST_BUSY_HOLDS_FRONT: assert property (@(posedge clk) disable iff (rst)
    busy |-> stall_front); // R9
  AST_FLUSH_ENTERS_WAIT: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> busy); // R9
  AST_NO_FLUSH_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !flush_all); // R10
  AST_REPLAY_AT_EXIT: assert property (@(posedge clk) disable iff (rst)
    replay |-> (!busy && $past(busy))); // R11
  AST_FLUSH_BEATS_KILL: assert property (@(posedge clk) disable iff (rst)
    flush_all |-> !kill_front); // R12
  AST_BUBBLE_CODES: assert property (@(posedge clk) disable iff (rst)
    $past(stall_front || flush_all) |-> (byp_a == '0 && byp_b == '0)); // R13
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (byp_a <= CODE_W'(MAX_CODE)) && (byp_b <= CODE_W'(MAX_CODE))); // R5
endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(.CODE_W(CODE_W), .MAX_CODE(DEPTH)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .stall_front (stall_front),
  .kill_front  (kill_front),
  .flush_all   (flush_all),
  .busy        (busy),
  .replay      (replay),
  .byp_a       (byp_a),
  .byp_b       (byp_b)
);

// File: tb/pipe_hazard_ctl_tb_top.sv
module pipe_hazard_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 37;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rf_valid = 1'b0;
  logic [4:0] rf_src_a = '0, rf_src_b = '0, rf_dst = '0;
  logic       rf_is_load = 1'b0, rf_is_branch = 1'b0;
  logic       ex_taken = 1'b0, tc_miss = 1'b0, refill_done = 1'b0;
  logic       stall_front, kill_front, flush_all, busy, replay;
  logic [2:0] byp_a, byp_b;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pipe_hazard_ctl dut_i (
    .clk(clk), .rst(rst), .rf_valid(rf_valid), .rf_src_a(rf_src_a),
    .rf_src_b(rf_src_b), .rf_dst(rf_dst), .rf_is_load(rf_is_load),
    .rf_is_branch(rf_is_branch), .ex_taken(ex_taken), .tc_miss(tc_miss),
    .refill_done(refill_done), .stall_front(stall_front),
    .kill_front(kill_front), .flush_all(flush_all), .busy(busy),
    .replay(replay), .byp_a(byp_a), .byp_b(byp_b)
  );

  // row: {valid, srcA, srcB, dst, {ld,br,taken,miss,refill},
  //       expected {stall,kill,flush,busy,replay}, expA, expB}
  localparam logic [31:0] VEC [0:NV-1] = '{
    {1'b1,5'd2, 5'd0, 5'd1, 5'b10000,5'b00000,3'd0,3'd0}, // R1 load r1
    {1'b1,5'd1, 5'd3, 5'd4, 5'b00000,5'b10000,3'd0,3'd0}, // R2 hold 1
    {1'b1,5'd1, 5'd3, 5'd4, 5'b00000,5'b10000,3'd0,3'd0}, // R2 hold 2
    {1'b1,5'd1, 5'd3, 5'd4, 5'b00000,5'b00000,3'd0,3'd0}, // R2 released
    {1'b1,5'd4, 5'd1, 5'd5, 5'b00000,5'b00000,3'd3,3'd0}, // R4 load code 3
    {1'b1,5'd0, 5'd0, 5'd0, 5'b00000,5'b00000,3'd1,3'd4}, // R5 codes 1 and 4
    {1'b1,5'd5, 5'd4, 5'd7, 5'b10000,5'b00000,3'd0,3'd0}, // R6 zero srcs
    {1'b1,5'd8, 5'd9, 5'd10,5'b00000,5'b00000,3'd2,3'd3}, // R6 dst0 skipped
    {1'b1,5'd7, 5'd10,5'd11,5'b00000,5'b10000,3'd0,3'd0}, // R3 one hold
    {1'b1,5'd7, 5'd10,5'd11,5'b00000,5'b00000,3'd0,3'd0}, // R13 bubble
    {1'b1,5'd10,5'd11,5'd10,5'b00000,5'b00000,3'd3,3'd2}, // R4
    {1'b1,5'd10,5'd11,5'd12,5'b00000,5'b00000,3'd3,3'd1}, // R5
    {1'b1,5'd12,5'd0, 5'd0, 5'b01000,5'b00000,3'd1,3'd2}, // R5 youngest
    {1'b1,5'd1, 5'd2, 5'd13,5'b00100,5'b01000,3'd1,3'd0}, // R7 taken
    {1'b0,5'd0, 5'd0, 5'd0, 5'b00100,5'b00000,3'd0,3'd0}, // R8 no branch
    {1'b1,5'd0, 5'd0, 5'd0, 5'b01000,5'b00000,3'd0,3'd0}, // R7 slot entered
    {1'b1,5'd13,5'd0, 5'd14,5'b00000,5'b00000,3'd0,3'd0}, // R8 untaken
    {1'b0,5'd0, 5'd0, 5'd0, 5'b00000,5'b00000,3'd3,3'd0}, // R5
    {1'b1,5'd0, 5'd0, 5'd20,5'b10000,5'b00000,3'd0,3'd0}, // R9 load
    {1'b1,5'd0, 5'd0, 5'd0, 5'b00000,5'b00000,3'd0,3'd0}, // R9
    {1'b1,5'd0, 5'd0, 5'd0, 5'b00000,5'b00000,3'd0,3'd0}, // R9
    {1'b1,5'd0, 5'd0, 5'd0, 5'b01000,5'b00000,3'd0,3'd0}, // R9 branch
    {1'b1,5'd0, 5'd0, 5'd23,5'b00110,5'b00100,3'd0,3'd0}, // R12 miss wins
    {1'b0,5'd0, 5'd0, 5'd0, 5'b00000,5'b10010,3'd0,3'd0}, // R9 busy
    {1'b1,5'd0, 5'd0, 5'd24,5'b00010,5'b10010,3'd0,3'd0}, // R10 miss in wait
    {1'b0,5'd0, 5'd0, 5'd0, 5'b00001,5'b10010,3'd0,3'd0}, // R11 refill
    {1'b0,5'd0, 5'd0, 5'd0, 5'b00000,5'b00001,3'd0,3'd0}, // R11 replay
    {1'b0,5'd0, 5'd0, 5'd0, 5'b00000,5'b00000,3'd0,3'd0}, // R11 pulse ends
    {1'b1,5'd0, 5'd0, 5'd25,5'b00000,5'b00000,3'd0,3'd0}, // R10 non-load
    {1'b0,5'd0, 5'd0, 5'd0, 5'b00000,5'b00000,3'd0,3'd0}, // R10
    {1'b0,5'd0, 5'd0, 5'd0, 5'b00000,5'b00000,3'd0,3'd0}, // R10
    {1'b0,5'd0, 5'd0, 5'd0, 5'b00000,5'b00000,3'd0,3'd0}, // R10
    {1'b0,5'd0, 5'd0, 5'd0, 5'b00010,5'b00000,3'd0,3'd0}, // R10 miss ignored
    {1'b0,5'd0, 5'd0, 5'd0, 5'b00000,5'b00000,3'd0,3'd0}, // R10 no busy
    {1'b1,5'd0, 5'd0, 5'd0, 5'b10000,5'b00000,3'd0,3'd0}, // R6 load r0
    {1'b1,5'd0, 5'd0, 5'd26,5'b00000,5'b00000,3'd0,3'd0}, // R6 no hold
    {1'b0,5'd0, 5'd0, 5'd0, 5'b00000,5'b00000,3'd0,3'd0}  // R6
  };
  localparam int REQ [0:NV-1] = '{1,2,2,2,4,5,6,6,3,13,4,5,5,7,8,7,8,5,9,9,9,9,
                                  12,9,10,11,11,11,10,10,10,10,10,10,6,6,6};

  task automatic drive(input logic v, input logic [4:0] a, input logic [4:0] b,
                       input logic [4:0] d, input logic [4:0] fl);
    rf_valid = v; rf_src_a = a; rf_src_b = b; rf_dst = d;
    {rf_is_load, rf_is_branch, ex_taken, tc_miss, refill_done} = fl;
  endtask

  task automatic check(input int req, input logic [10:0] exp_v);
    logic [10:0] act;
    act = {stall_front, kill_front, flush_all, busy, replay, byp_a, byp_b};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL R%0d: {stall,kill,flush,busy,replay,a,b} got %b expected %b",
               req, act, exp_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    drive(1'b1, 5'd3, 5'd4, 5'd0, 5'b00000);
    #1 check(1, 11'b0); // R1 reset state
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VEC[k][31], VEC[k][30:26], VEC[k][25:21], VEC[k][20:16], VEC[k][15:11]);
      #1 check(REQ[k], VEC[k][10:0]);
    end

    // R1: reset taken during a refill wait
    @(negedge clk); drive(1'b1, 5'd0, 5'd0, 5'd3, 5'b10000);
    @(negedge clk); drive(1'b0, 5'd0, 5'd0, 5'd0, 5'b00000);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); drive(1'b0, 5'd0, 5'd0, 5'd0, 5'b00010);
    #1 check(9, {5'b00100, 6'd0}); // R9 flush on missed load
    @(negedge clk); drive(1'b0, 5'd0, 5'd0, 5'd0, 5'b00000);
    #1 check(9, {5'b10010, 6'd0});
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive(1'b1, 5'd3, 5'd3, 5'd5, 5'b00000);
    #1 check(1, 11'b0); // R1 wait state cleared, no hold
    @(negedge clk); drive(1'b0, 5'd0, 5'd0, 5'd0, 5'b00000);
    #1 check(1, 11'b0); // R1 nothing in flight to bypass from

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule